// File: doc/BRIEF.md
# Counted Loop Branch Unit

This block computes the next instruction pointer for three kinds of control flow: plain sequential advance, an unconditional relative jump, and a counted loop branch that decrements a count register and branches back while the count has not run out. It holds the instruction pointer and the count in its own registers. Both can be preset through a load port. After that, each step request with an operation code, an instruction length and a relative displacement moves the state forward by one instruction.

All branch targets are measured from the address of the instruction that follows the current one. The displacement comes either as a short signed byte or as a full-width word. The loop operation decrements the count before it tests it. A loop entered with a count of zero therefore wraps to all ones and runs the full 2^32 iterations. All pointer and count arithmetic wraps modulo 2^32. No status flags exist, so none are changed.

Top module: `loopbr_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the pointer, the count and `taken` all become zero on that edge.
- R2: When `load_en` is high at an edge, the pointer takes `load_ip`, the count takes `load_cnt` and `taken` goes low, whatever `step_en` and `op` are.
- R3: A step with `op` 0 (sequential) or 3 (reserved, handled as sequential) sets the pointer to pointer + `ilen` modulo 2^32, leaves the count unchanged and drives `taken` low.
- R4: A step with `op` 1 (jump) sets the pointer to pointer + `ilen` + displacement modulo 2^32, leaves the count unchanged and drives `taken` high.
- R5: A step with `op` 2 (loop) replaces the count by count − 1 modulo 2^32.
- R6: In a loop step whose decremented count is nonzero, the pointer becomes pointer + `ilen` + displacement and `taken` goes high.
- R7: In a loop step whose decremented count is zero, the pointer becomes pointer + `ilen` and `taken` goes low.
- R8: With `short_off` high, the displacement is `rel_off[7:0]` sign-extended, so it spans −128 to +127 and bits 31:8 of `rel_off` have no effect. For example, pointer 0Ch, length 2 and byte FCh give 0Ah. With `short_off` low, the whole of `rel_off` is the displacement.
- R9: A loop step on a count of zero leaves FFFF_FFFFh in the count and takes the branch.
- R10: An edge with neither `load_en` nor `step_en` keeps the pointer and the count and drives `taken` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Preset pointer and count; wins over a step |
| load_ip | input | 32 | Pointer value to preset |
| load_cnt | input | 32 | Count value to preset |
| step_en | input | 1 | Advance by one instruction |
| op | input | 2 | 0 sequential, 1 jump, 2 loop, 3 sequential |
| ilen | input | 4 | Length in bytes of the current instruction |
| short_off | input | 1 | 1: byte displacement, 0: word displacement |
| rel_off | input | 32 | Signed relative displacement |
| ip_q | output | 32 | Registered instruction pointer |
| cnt_q | output | 32 | Registered count |
| taken_q | output | 1 | Last step redirected the pointer |

## Verification
The assertions assume that every input is at a known value at each clock edge once reset is released. They also assume that a load or step request lasts exactly one cycle per intended operation, so each next-cycle property compares against a single request. The stimulus drives every input on the falling edge and draws random operation codes, lengths from 1 to 15, and displacements in both widths. The random part also reloads small counts often, so loop exits and zero-count wraps come up many times.

// File: rtl/loopbr_pkg.sv
package loopbr_pkg;
  typedef enum logic [1:0] {
    OP_SEQ  = 2'd0,
    OP_JMP  = 2'd1,
    OP_LOOP = 2'd2,
    OP_RSVD = 2'd3
  } br_op_e;
endpackage

// File: rtl/loopbr_target.sv
// Computes fall-through and branch-target addresses.
module loopbr_target #(
  parameter int AW = 32,
  parameter int LW = 4,
  parameter int SW = 8
) (
  input  logic [AW-1:0] ip,
  input  logic [LW-1:0] ilen,
  input  logic          short_sel,
  input  logic [AW-1:0] rel_off,
  output logic [AW-1:0] seq_ip,
  output logic [AW-1:0] tgt_ip
);
  localparam int PADL = AW - LW;
  logic [AW-1:0] disp;

  generate
    if (SW < AW) begin : g_narrow
      localparam int PADS = AW - SW;
      assign disp = short_sel ? {{PADS{rel_off[SW-1]}}, rel_off[SW-1:0]}
                              : rel_off;
    end else begin : g_full
      assign disp = rel_off;
    end
  endgenerate

  assign seq_ip = ip + {{PADL{1'b0}}, ilen};
  assign tgt_ip = seq_ip + disp;
endmodule

// File: rtl/loopbr_count.sv
// Decrement-then-test for the loop count.
module loopbr_count #(
  parameter int CW = 32
) (
  input  logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_dec,
  output logic          dec_nz
);
  assign cnt_dec = cnt - {{(CW-1){1'b0}}, 1'b1};
  assign dec_nz  = |cnt_dec;
endmodule

// File: rtl/loopbr_decide.sv
// Chooses next pointer, count and redirect flag for one step.
module loopbr_decide #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  loopbr_pkg::br_op_e op,
  input  logic [AW-1:0]      seq_ip,
  input  logic [AW-1:0]      tgt_ip,
  input  logic [CW-1:0]      cnt,
  input  logic [CW-1:0]      cnt_dec,
  input  logic               dec_nz,
  output logic [AW-1:0]      nxt_ip,
  output logic [CW-1:0]      nxt_cnt,
  output logic               nxt_taken
);
  import loopbr_pkg::*;

  always_comb begin
    nxt_ip    = seq_ip;
    nxt_cnt   = cnt;
    nxt_taken = 1'b0;
    unique case (op)
      OP_JMP: begin
        nxt_ip    = tgt_ip;
        nxt_taken = 1'b1;
      end
      OP_LOOP: begin
        nxt_cnt = cnt_dec;
        if (dec_nz) begin
          nxt_ip    = tgt_ip;
          nxt_taken = 1'b1;
        end
      end
      default: begin
        nxt_ip = seq_ip;
      end
    endcase
  end
endmodule

// File: rtl/loopbr_unit.sv
module loopbr_unit #(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int LW = 4,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [AW-1:0] load_ip,
  input  logic [CW-1:0] load_cnt,
  input  logic          step_en,
  input  logic [1:0]    op,
  input  logic [LW-1:0] ilen,
  input  logic          short_off,
  input  logic [AW-1:0] rel_off,
  output logic [AW-1:0] ip_q,
  output logic [CW-1:0] cnt_q,
  output logic          taken_q
);
  import loopbr_pkg::*;

  logic [AW-1:0] seq_ip, tgt_ip, nxt_ip;
  logic [CW-1:0] cnt_dec, nxt_cnt;
  logic          dec_nz, nxt_taken;
  br_op_e        op_e;

  assign op_e = br_op_e'(op);

  loopbr_target #(.AW(AW), .LW(LW), .SW(SW)) tgt_i (
    .ip(ip_q), .ilen(ilen), .short_sel(short_off), .rel_off(rel_off),
    .seq_ip(seq_ip), .tgt_ip(tgt_ip)
  );

  loopbr_count #(.CW(CW)) cnt_i (
    .cnt(cnt_q), .cnt_dec(cnt_dec), .dec_nz(dec_nz)
  );

  loopbr_decide #(.AW(AW), .CW(CW)) dec_i (
    .op(op_e), .seq_ip(seq_ip), .tgt_ip(tgt_ip), .cnt(cnt_q),
    .cnt_dec(cnt_dec), .dec_nz(dec_nz),
    .nxt_ip(nxt_ip), .nxt_cnt(nxt_cnt), .nxt_taken(nxt_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ip_q    <= '0;
      cnt_q   <= '0;
      taken_q <= 1'b0;
    end else if (load_en) begin
      ip_q    <= load_ip;
      cnt_q   <= load_cnt;
      taken_q <= 1'b0;
    end else if (step_en) begin
      ip_q    <= nxt_ip;
      cnt_q   <= nxt_cnt;
      taken_q <= nxt_taken;
    end else begin
      taken_q <= 1'b0;
    end
  end
endmodule

// File: rtl/loopbr_chk.sv
module loopbr_chk #(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int LW = 4,
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          load_en,
  input logic [AW-1:0] load_ip,
  input logic [CW-1:0] load_cnt,
  input logic          step_en,
  input logic [1:0]    op,
  input logic [LW-1:0] ilen,
  input logic          short_off,
  input logic [AW-1:0] rel_off,
  input logic [AW-1:0] ip_q,
  input logic [CW-1:0] cnt_q,
  input logic          taken_q
);
  logic stp;
  logic [AW-1:0] len_x, sdisp;
  assign stp   = step_en && !load_en;
  assign len_x = AW'(ilen);
  assign sdisp = AW'($signed(rel_off[SW-1:0]));

  // R2
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (ip_q == $past(load_ip)) && (cnt_q == $past(load_cnt)) && !taken_q);

  // R3
  seq_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (stp && (op == 2'd0 || op == 2'd3)) |=>
      (ip_q == $past(ip_q) + $past(len_x)) && $stable(cnt_q) && !taken_q);

  // R4
  jmp_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (stp && op == 2'd1) |=> taken_q && $stable(cnt_q));

  // R5
  loop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (stp && op == 2'd2) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R7
  loop_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (stp && op == 2'd2 && cnt_q == CW'(1)) |=>
      !taken_q && (ip_q == $past(ip_q) + $past(len_x)));

  // R8
  short_jmp_chk: assert property (@(posedge clk) disable iff (rst)
    (stp && op == 2'd1 && short_off) |=>
      ip_q == $past(ip_q) + $past(len_x) + $past(sdisp));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !step_en) |=> $stable(ip_q) && $stable(cnt_q) && !taken_q);
endmodule

bind loopbr_unit loopbr_chk #(.AW(AW), .CW(CW), .LW(LW), .SW(SW)) chk_i (
  .clk(clk), .rst(rst), .load_en(load_en), .load_ip(load_ip),
  .load_cnt(load_cnt), .step_en(step_en), .op(op), .ilen(ilen),
  .short_off(short_off), .rel_off(rel_off), .ip_q(ip_q), .cnt_q(cnt_q),
  .taken_q(taken_q)
);

// File: tb/loopbr_unit_tb_top.sv
`timescale 1ns/1ps
module loopbr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic [31:0] load_ip = '0;
  logic [31:0] load_cnt = '0;
  logic        step_en = 1'b0;
  logic [1:0]  op = '0;
  logic [3:0]  ilen = '0;
  logic        short_off = 1'b0;
  logic [31:0] rel_off = '0;
  logic [31:0] ip_q, cnt_q;
  logic        taken_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] e_ip = '0, e_cnt = '0;
  logic        e_tk = 1'b0;

  always #2 clk = ~clk;

  loopbr_unit dut_i (
    .clk(clk), .rst(rst), .load_en(load_en), .load_ip(load_ip),
    .load_cnt(load_cnt), .step_en(step_en), .op(op), .ilen(ilen),
    .short_off(short_off), .rel_off(rel_off), .ip_q(ip_q), .cnt_q(cnt_q),
    .taken_q(taken_q)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tip, input string tcnt, input string ttk);
    chk(ip_q === e_ip, tip, ip_q, e_ip);
    chk(cnt_q === e_cnt, tcnt, cnt_q, e_cnt);
    chk(taken_q === e_tk, ttk, {31'b0, taken_q}, {31'b0, e_tk});
  endtask

  function automatic logic [31:0] disp_of(input logic s, input logic [31:0] o);
    return s ? {{24{o[7]}}, o[7:0]} : o;
  endfunction

  task automatic do_load(input logic [31:0] ip, input logic [31:0] c,
                         input logic st, input logic [1:0] o);
    load_en = 1'b1; load_ip = ip; load_cnt = c; step_en = st; op = o;
    ilen = 4'd3; rel_off = 32'h10;
    @(negedge clk);
    load_en = 1'b0; step_en = 1'b0;
    e_ip = ip; e_cnt = c; e_tk = 1'b0;
    check_state("R2 ip", "R2 cnt", "R2 taken");
  endtask

  task automatic do_step(input logic [1:0] o, input logic [3:0] l,
                         input logic s, input logic [31:0] off,
                         input string tip, input string tcnt, input string ttk);
    logic [31:0] seq, tgt;
    step_en = 1'b1; op = o; ilen = l; short_off = s; rel_off = off;
    seq = e_ip + {28'b0, l};
    tgt = seq + disp_of(s, off);
    case (o)
      2'd1: begin e_ip = tgt; e_tk = 1'b1; end
      2'd2: begin
        e_cnt = e_cnt - 1;
        if (e_cnt != 0) begin e_ip = tgt; e_tk = 1'b1; end
        else begin e_ip = seq; e_tk = 1'b0; end
      end
      default: begin e_ip = seq; e_tk = 1'b0; end
    endcase
    @(negedge clk);
    step_en = 1'b0;
    check_state(tip, tcnt, ttk);
  endtask

  initial begin
    int unsigned cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<=100000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check_state("R1 ip", "R1 cnt", "R1 taken");

    do_load(32'h0000_000C, 32'd5, 1'b0, 2'd0);
    // R8 / R6: byte FCh from next address 0Eh lands at 0Ah, upper bits ignored
    do_step(2'd2, 4'd2, 1'b1, 32'hABCD_EFFC, "R8 ip", "R5 cnt", "R6 taken");
    chk(ip_q === 32'h0A, "R8 example", ip_q, 32'h0A);
    // R8: extreme byte displacements
    do_step(2'd1, 4'd2, 1'b1, 32'h0000_007F, "R8 +127 ip", "R4 cnt", "R4 taken");
    do_step(2'd1, 4'd2, 1'b1, 32'hFFFF_FF80, "R8 -128 ip", "R4 cnt", "R4 taken");
    // R4: full-width negative displacement
    do_step(2'd1, 4'd5, 1'b0, 32'hFFFF_0000, "R4 ip", "R4 cnt", "R4 taken");
    // R7: count 1 falls through to zero
    do_load(32'h0000_1000, 32'd1, 1'b0, 2'd0);
    do_step(2'd2, 4'd2, 1'b1, 32'h0000_00F0, "R7 ip", "R5 cnt", "R7 taken");
    // R9: count zero wraps and branches
    do_step(2'd2, 4'd2, 1'b1, 32'h0000_00F0, "R9 ip", "R9 cnt", "R9 taken");
    chk(cnt_q === 32'hFFFF_FFFF, "R9 wrap", cnt_q, 32'hFFFF_FFFF);
    // R3: pointer wrap and reserved code
    do_load(32'hFFFF_FFFE, 32'd7, 1'b0, 2'd0);
    do_step(2'd0, 4'd3, 1'b0, 32'h1234_5678, "R3 wrap ip", "R3 cnt", "R3 taken");
    do_step(2'd3, 4'd4, 1'b0, 32'h1234_5678, "R3 rsvd ip", "R3 cnt", "R3 taken");
    // R10: idle
    do_step(2'd1, 4'd1, 1'b1, 32'h4, "R4 ip", "R4 cnt", "R4 taken");
    @(negedge clk);
    e_tk = 1'b0;
    check_state("R10 ip", "R10 cnt", "R10 taken");
    // R2: load wins over a jump step
    do_load(32'h0000_2222, 32'd9, 1'b1, 2'd1);
    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    e_ip = '0; e_cnt = '0; e_tk = 1'b0;
    check_state("R1 ip", "R1 cnt", "R1 taken");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] o;
      logic [3:0] l;
      logic s;
      logic [31:0] off;
      if ($urandom_range(0, 9) == 0)
        do_load($urandom, 32'($urandom_range(0, 3)), 1'b0, 2'd0);
      o   = 2'($urandom_range(0, 3));
      l   = 4'($urandom_range(1, 15));
      s   = 1'($urandom_range(0, 1));
      off = $urandom;
      if (o == 2'd2)
        do_step(o, l, s, off, (e_cnt == 32'd1) ? "R7 ip" : "R6 ip", "R5 cnt",
                (e_cnt == 32'd1) ? "R7 taken" : "R6 taken");
      else if (o == 2'd1)
        do_step(o, l, s, off, s ? "R8 ip" : "R4 ip", "R4 cnt", "R4 taken");
      else
        do_step(o, l, s, off, "R3 ip", "R3 cnt", "R3 taken");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule